// File: doc/BRIEF.md
# Privilege Mode and Trap Controller

This block keeps track of whether a hart runs in machine mode or in user mode. It decides the outcome of every instruction event that can change that mode or depend on it. The decode stage sends at most one event per cycle: an environment call, a trap return, a wait-for-interrupt, a CSR access with its address, write intent and write data, or some other machine-only instruction. The block checks each event against the current mode. It then raises a trap and reports its cause and saved PC, performs the return, parks the hart in a wait state, or lets the event pass.

The block owns the status bits that trap entry and return use: the global interrupt enable, its saved copy, the saved previous mode, and the timeout-wait control bit. It also owns the per-counter user read-permission mask. Interrupt lines arrive as separate pending and enable vectors. An interrupt trap is taken when the global enable is set and at least one line is both pending and enabled. The lowest-numbered such line wins. The vector address, the remaining CSRs and the pipeline are outside this block. The trap outputs carry everything a fetch unit needs to redirect.

All outputs are registered. An event presented before a clock edge shows its effect on the outputs right after that edge.

Top module: `priv_trap_ctrl`

## Requirements
- R1: After reset the hart is in M-mode (priv_o = 2'b11), mstatus_o is 0 (MIE, MPIE and TW clear, saved mode U), mcounteren_o is 0, and wfi_stall_o, trap_o and illegal_o are low.
- R2: An ecall always traps to M-mode with mepc_o equal to its PC. mcause_o is 8 when the ecall came from U-mode and 11 when it came from M-mode.
- R3: On every trap, the saved-mode field mstatus_o[12:11] takes the mode that was active before the trap, MPIE (bit 7) takes MIE, MIE (bit 3) clears, and priv_o becomes M.
- R4: In M-mode, mret sets the mode to the saved mode, restores MIE from MPIE, sets MPIE to 1 and sets the saved mode to U. In U-mode, mret raises an illegal-instruction trap (mcause 2, illegal_o high, mepc = its PC).
- R5: In U-mode, any other machine-only instruction raises an illegal-instruction trap, and so does any CSR access other than a permitted counter read.
- R6: A U-mode read of counter CSR 0xC00+x is legal only if x < NCNT and mcounteren bit x is 1; otherwise it traps as illegal. A write to any CSR with address bits [11:10] = 2'b11 is illegal in either mode.
- R7: A legal WFI with MIE = 1 raises wfi_stall_o until a line is both pending and enabled. It then traps with mcause = 2^31 + line index and mepc = WFI PC + 4.
- R8: A legal WFI with MIE = 0 raises wfi_stall_o until any line is pending, enabled or not. The stall then drops with no trap and no state change.
- R9: With TW (mstatus bit 21) set, WFI in U-mode traps at once as illegal. In M-mode it stalls as usual.
- R10: Outside a WFI stall, when MIE = 1 and a line is pending and enabled, an interrupt trap is taken with mepc = ev_pc_i, and the event of that cycle is discarded.
- R11: In M-mode, a CSR write to 0x300 loads MIE (bit 3), MPIE (bit 7), TW (bit 21) and the saved mode (bits 12:11: 2'b11 gives M, any other value gives U). A CSR write to 0x306 loads mcounteren from the low NCNT bits. All other mstatus_o bits read 0.
- R12: Event codes on ev_kind_i are 1 ecall, 2 mret, 3 WFI, 4 CSR access, 5 other machine-only instruction, 0 none. Outputs change on the edge that consumes an event, trap_o and illegal_o are single-cycle pulses, and events arriving during a stall are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid_i | input | 1 | An instruction event is presented |
| ev_kind_i | input | 3 | Event code (see R12) |
| ev_pc_i | input | XLEN | PC of the event, also the interrupted PC |
| csr_addr_i | input | 12 | CSR address for a CSR event |
| csr_wr_i | input | 1 | The CSR event writes |
| csr_wdata_i | input | XLEN | CSR write data |
| irq_pend_i | input | NIRQ | Pending interrupt lines |
| irq_en_i | input | NIRQ | Enabled interrupt lines |
| trap_o | output | 1 | One-cycle trap pulse |
| mcause_o | output | XLEN | Cause of the last trap |
| mepc_o | output | XLEN | Saved PC of the last trap |
| priv_o | output | 2 | Current mode (2'b11 M, 2'b00 U) |
| wfi_stall_o | output | 1 | Hart parked in WFI |
| illegal_o | output | 1 | One-cycle illegal-instruction pulse |
| mstatus_o | output | XLEN | Status bits owned by the block |
| mcounteren_o | output | NCNT | Counter read-permission mask |

## Verification
The bench builds the block with NIRQ = 4 and NCNT = 8. With only eight implemented counters, addresses 0xC08 to 0xC1F fall inside the counter window but have no permission bit, so the out-of-range branch of R6 can be exercised. Four interrupt lines are enough to raise a pending but disabled line alongside an enabled one. That pattern separates the two wake rules of R7 and R8 and shows lowest-index priority. A behavioural model steps alongside the block and compares every output on every cycle, while directed scenarios walk through the mode changes.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;

  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_M = 2'b11
  } priv_e;

  typedef enum logic [2:0] {
    EV_NONE  = 3'd0,
    EV_ECALL = 3'd1,
    EV_MRET  = 3'd2,
    EV_WFI   = 3'd3,
    EV_CSR   = 3'd4,
    EV_MPRIV = 3'd5
  } ev_e;

  localparam int unsigned CAUSE_ILLEGAL = 2;
  localparam int unsigned CAUSE_ECALL_U = 8;
  localparam int unsigned CAUSE_ECALL_M = 11;

  localparam logic [11:0] CSR_STATUS  = 12'h300;
  localparam logic [11:0] CSR_CNTPERM = 12'h306;
  localparam logic [6:0]  CNT_WINDOW  = 7'b1100000;

  localparam int unsigned BIT_MIE  = 3;
  localparam int unsigned BIT_MPIE = 7;
  localparam int unsigned BIT_MPPL = 11;
  localparam int unsigned BIT_MPPH = 12;
  localparam int unsigned BIT_TW   = 21;

endpackage

// File: rtl/ptc_legality.sv
module ptc_legality
  import priv_trap_pkg::*;
#(
  parameter int NCNT = 32
) (
  input  logic [2:0]      kind_i,
  input  logic [11:0]     addr_i,
  input  logic            wr_i,
  input  logic            is_m_i,
  input  logic            tw_i,
  input  logic [NCNT-1:0] cnt_en_i,
  output logic            illegal_o
);
  logic [31:0] en_wide;
  logic        in_window;
  logic        cnt_ok;
  logic        read_only;

  always_comb begin
    en_wide = '0;
    en_wide[NCNT-1:0] = cnt_en_i;
  end

  assign in_window = (addr_i[11:5] == CNT_WINDOW) && (int'(addr_i[4:0]) < NCNT);
  assign cnt_ok    = in_window && en_wide[addr_i[4:0]] && !wr_i;
  assign read_only = (addr_i[11:10] == 2'b11);

  always_comb begin
    illegal_o = 1'b0;
    unique case (ev_e'(kind_i))
      EV_MRET, EV_MPRIV: illegal_o = !is_m_i;
      EV_WFI:            illegal_o = !is_m_i && tw_i;
      EV_CSR:            illegal_o = (wr_i && read_only) || (!is_m_i && !cnt_ok);
      default:           illegal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ptc_irq_select.sv
module ptc_irq_select #(
  parameter int NIRQ = 4,
  localparam int IW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic [NIRQ-1:0] pend_i,
  input  logic [NIRQ-1:0] en_i,
  output logic            any_en_o,
  output logic            any_pend_o,
  output logic [IW-1:0]   idx_o
);
  logic [NIRQ-1:0] live;
  assign live       = pend_i & en_i;
  assign any_en_o   = |live;
  assign any_pend_o = |pend_i;

  always_comb begin
    idx_o = '0;
    for (int i = NIRQ - 1; i >= 0; i--) begin
      if (live[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/ptc_wfi_park.sv
module ptc_wfi_park #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            mie_i,
  input  logic            any_en_i,
  input  logic            any_pend_i,
  output logic            stall_o,
  output logic            wake_trap_o,
  output logic            wake_go_o,
  output logic [XLEN-1:0] resume_pc_o
);
  logic            stall_q;
  logic [XLEN-1:0] rpc_q;

  assign wake_trap_o = stall_q && mie_i && any_en_i;
  assign wake_go_o   = stall_q && !mie_i && any_pend_i;
  assign stall_o     = stall_q;
  assign resume_pc_o = rpc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stall_q <= 1'b0;
      rpc_q   <= '0;
    end else if (start_i) begin
      stall_q <= 1'b1;
      rpc_q   <= pc_i + XLEN'(4);
    end else if (wake_trap_o || wake_go_o) begin
      stall_q <= 1'b0;
    end
  end
endmodule

// File: rtl/priv_trap_ctrl.sv
module priv_trap_ctrl
  import priv_trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NIRQ = 4,
  parameter int NCNT = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ev_valid_i,
  input  logic [2:0]      ev_kind_i,
  input  logic [XLEN-1:0] ev_pc_i,
  input  logic [11:0]     csr_addr_i,
  input  logic            csr_wr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  input  logic [NIRQ-1:0] irq_pend_i,
  input  logic [NIRQ-1:0] irq_en_i,
  output logic            trap_o,
  output logic [XLEN-1:0] mcause_o,
  output logic [XLEN-1:0] mepc_o,
  output logic [1:0]      priv_o,
  output logic            wfi_stall_o,
  output logic            illegal_o,
  output logic [XLEN-1:0] mstatus_o,
  output logic [NCNT-1:0] mcounteren_o
);
  localparam int IW = (NIRQ > 1) ? $clog2(NIRQ) : 1;

  priv_e           priv_q;
  priv_e           mpp_q;
  logic            mie_q, mpie_q, tw_q;
  logic [NCNT-1:0] cnt_q;
  logic            trap_q, ill_q;
  logic [XLEN-1:0] cause_q, epc_q;

  logic            is_m;
  logic            ev_illegal;
  logic            any_en, any_pend;
  logic [IW-1:0]   irq_idx;
  logic            stall, wake_trap, wake_go;
  logic [XLEN-1:0] resume_pc;

  logic            take_trap, take_ill, do_mret, wfi_start;
  logic            wr_status, wr_cntperm;
  logic [XLEN-1:0] cause_n, epc_n, irq_cause;

  assign is_m = (priv_q == PRIV_M);

  ptc_legality #(.NCNT(NCNT)) u_legal (
    .kind_i    (ev_kind_i),
    .addr_i    (csr_addr_i),
    .wr_i      (csr_wr_i),
    .is_m_i    (is_m),
    .tw_i      (tw_q),
    .cnt_en_i  (cnt_q),
    .illegal_o (ev_illegal)
  );

  ptc_irq_select #(.NIRQ(NIRQ)) u_irq (
    .pend_i     (irq_pend_i),
    .en_i       (irq_en_i),
    .any_en_o   (any_en),
    .any_pend_o (any_pend),
    .idx_o      (irq_idx)
  );

  ptc_wfi_park #(.XLEN(XLEN)) u_park (
    .clk         (clk),
    .rst         (rst),
    .start_i     (wfi_start),
    .pc_i        (ev_pc_i),
    .mie_i       (mie_q),
    .any_en_i    (any_en),
    .any_pend_i  (any_pend),
    .stall_o     (stall),
    .wake_trap_o (wake_trap),
    .wake_go_o   (wake_go),
    .resume_pc_o (resume_pc)
  );

  always_comb begin
    irq_cause = '0;
    irq_cause[XLEN-1] = 1'b1;
    irq_cause[IW-1:0] = irq_idx;
  end

  always_comb begin
    take_trap  = 1'b0;
    take_ill   = 1'b0;
    do_mret    = 1'b0;
    wfi_start  = 1'b0;
    wr_status  = 1'b0;
    wr_cntperm = 1'b0;
    cause_n    = cause_q;
    epc_n      = epc_q;
    if (stall) begin
      if (wake_trap) begin
        take_trap = 1'b1;
        cause_n   = irq_cause;
        epc_n     = resume_pc;
      end
    end else if (mie_q && any_en) begin
      take_trap = 1'b1;
      cause_n   = irq_cause;
      epc_n     = ev_pc_i;
    end else if (ev_valid_i) begin
      if (ev_illegal) begin
        take_trap = 1'b1;
        take_ill  = 1'b1;
        cause_n   = XLEN'(CAUSE_ILLEGAL);
        epc_n     = ev_pc_i;
      end else begin
        unique case (ev_e'(ev_kind_i))
          EV_ECALL: begin
            take_trap = 1'b1;
            cause_n   = is_m ? XLEN'(CAUSE_ECALL_M) : XLEN'(CAUSE_ECALL_U);
            epc_n     = ev_pc_i;
          end
          EV_MRET: do_mret   = 1'b1;
          EV_WFI:  wfi_start = 1'b1;
          EV_CSR: begin
            wr_status  = csr_wr_i && is_m && (csr_addr_i == CSR_STATUS);
            wr_cntperm = csr_wr_i && is_m && (csr_addr_i == CSR_CNTPERM);
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      priv_q  <= PRIV_M;
      mpp_q   <= PRIV_U;
      mie_q   <= 1'b0;
      mpie_q  <= 1'b0;
      tw_q    <= 1'b0;
      cnt_q   <= '0;
      trap_q  <= 1'b0;
      ill_q   <= 1'b0;
      cause_q <= '0;
      epc_q   <= '0;
    end else begin
      trap_q <= take_trap;
      ill_q  <= take_ill;
      if (take_trap) begin
        cause_q <= cause_n;
        epc_q   <= epc_n;
        mpp_q   <= priv_q;
        mpie_q  <= mie_q;
        mie_q   <= 1'b0;
        priv_q  <= PRIV_M;
      end else if (do_mret) begin
        priv_q <= mpp_q;
        mie_q  <= mpie_q;
        mpie_q <= 1'b1;
        mpp_q  <= PRIV_U;
      end else if (wr_status) begin
        mie_q  <= csr_wdata_i[BIT_MIE];
        mpie_q <= csr_wdata_i[BIT_MPIE];
        tw_q   <= csr_wdata_i[BIT_TW];
        mpp_q  <= (csr_wdata_i[BIT_MPPH:BIT_MPPL] == 2'b11) ? PRIV_M : PRIV_U;
      end else if (wr_cntperm) begin
        cnt_q <= csr_wdata_i[NCNT-1:0];
      end
    end
  end

  always_comb begin
    mstatus_o = '0;
    mstatus_o[BIT_MIE]           = mie_q;
    mstatus_o[BIT_MPIE]          = mpie_q;
    mstatus_o[BIT_MPPH:BIT_MPPL] = mpp_q;
    mstatus_o[BIT_TW]            = tw_q;
  end

  assign trap_o       = trap_q;
  assign illegal_o    = ill_q;
  assign mcause_o     = cause_q;
  assign mepc_o       = epc_q;
  assign priv_o       = priv_q;
  assign wfi_stall_o  = stall;
  assign mcounteren_o = cnt_q;
endmodule

// File: rtl/ptc_checker.sv
module ptc_checker #(
  parameter int XLEN = 32,
  parameter int NCNT = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            trap_o,
  input logic [XLEN-1:0] mcause_o,
  input logic [1:0]      priv_o,
  input logic            wfi_stall_o,
  input logic            illegal_o,
  input logic [XLEN-1:0] mstatus_o,
  input logic [NCNT-1:0] mcounteren_o
);
  // R1: first cycle after reset
  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (priv_o == 2'b11 && mcounteren_o == '0 && !wfi_stall_o));

  // R3: every trap lands in M-mode with MIE cleared
  p_trap_lands_m_r3: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> (priv_o == 2'b11 && !mstatus_o[3]));

  // R2: synchronous cause codes are limited to the defined ones
  p_sync_cause_r2: assert property (@(posedge clk) disable iff (rst)
    (trap_o && !mcause_o[XLEN-1]) |->
      (mcause_o == XLEN'(2) || mcause_o == XLEN'(8) || mcause_o == XLEN'(11)));

  // R5: illegal pulse always comes with a cause-2 trap
  p_illegal_cause_r5: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (trap_o && mcause_o == XLEN'(2)));

  // R12: mode holds while parked unless a wake trap occurs
  p_stall_holds_r12: assert property (@(posedge clk) disable iff (rst)
    wfi_stall_o |=> (trap_o || $stable(priv_o)));

  // R11: the saved-mode field only ever holds U or M
  p_mpp_legal_r11: assert property (@(posedge clk) disable iff (rst)
    (mstatus_o[12:11] == 2'b00 || mstatus_o[12:11] == 2'b11));

  // R1: mode output is always a supported mode
  p_priv_legal_r1: assert property (@(posedge clk) disable iff (rst)
    (priv_o == 2'b00 || priv_o == 2'b11));
endmodule

bind priv_trap_ctrl ptc_checker #(.XLEN(XLEN), .NCNT(NCNT)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .trap_o       (trap_o),
  .mcause_o     (mcause_o),
  .priv_o       (priv_o),
  .wfi_stall_o  (wfi_stall_o),
  .illegal_o    (illegal_o),
  .mstatus_o    (mstatus_o),
  .mcounteren_o (mcounteren_o)
);

// File: tb/priv_trap_ctrl_tb.sv
module priv_trap_ctrl_tb;
  localparam int XLEN = 32;
  localparam int NIRQ = 4;
  localparam int NCNT = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            ev_valid = 1'b0;
  logic [2:0]      ev_kind = 3'd0;
  logic [XLEN-1:0] ev_pc = '0;
  logic [11:0]     csr_addr = '0;
  logic            csr_wr = 1'b0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic [NIRQ-1:0] irq_pend = '0;
  logic [NIRQ-1:0] irq_en = '0;
  logic            trap_o, wfi_stall_o, illegal_o;
  logic [XLEN-1:0] mcause_o, mepc_o, mstatus_o;
  logic [1:0]      priv_o;
  logic [NCNT-1:0] mcounteren_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  priv_trap_ctrl #(.XLEN(XLEN), .NIRQ(NIRQ), .NCNT(NCNT)) u_dut (
    .clk(clk), .rst(rst), .ev_valid_i(ev_valid), .ev_kind_i(ev_kind),
    .ev_pc_i(ev_pc), .csr_addr_i(csr_addr), .csr_wr_i(csr_wr),
    .csr_wdata_i(csr_wdata), .irq_pend_i(irq_pend), .irq_en_i(irq_en),
    .trap_o(trap_o), .mcause_o(mcause_o), .mepc_o(mepc_o), .priv_o(priv_o),
    .wfi_stall_o(wfi_stall_o), .illegal_o(illegal_o), .mstatus_o(mstatus_o),
    .mcounteren_o(mcounteren_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int       m_priv;
  int       m_mpp;
  bit       m_mie, m_mpie, m_tw, m_stall, m_trap, m_ill;
  bit [7:0] m_cnt;
  bit [31:0] m_cause, m_epc, m_rpc;

  function automatic int lowest(input bit [NIRQ-1:0] v);
    for (int i = 0; i < NIRQ; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic bit m_is_illegal();
    bit ro;
    bit perm;
    int idx;
    ro = (csr_addr[11:10] == 2'b11);
    idx = int'(csr_addr[4:0]);
    perm = (csr_addr[11:5] == 7'h60) && idx < NCNT && m_cnt[idx % NCNT] && !csr_wr;
    case (ev_kind)
      3'd2, 3'd5: return m_priv == 0;
      3'd3:       return m_priv == 0 && m_tw;
      3'd4:       return (csr_wr && ro) || (m_priv == 0 && !perm);
      default:    return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_priv = 3; m_mpp = 0; m_mie = 0; m_mpie = 0; m_tw = 0; m_cnt = 0;
      m_stall = 0; m_trap = 0; m_ill = 0; m_cause = 0; m_epc = 0; m_rpc = 0;
    end else begin
      bit tr, il, en_any;
      bit [31:0] cs, ep;
      tr = 0; il = 0; cs = 0; ep = 0;
      en_any = |(irq_pend & irq_en);
      if (m_stall) begin
        if (m_mie && en_any) begin
          tr = 1; cs = 32'h8000_0000 | lowest(irq_pend & irq_en); ep = m_rpc; m_stall = 0;
        end else if (!m_mie && |irq_pend) m_stall = 0;
      end else if (m_mie && en_any) begin
        tr = 1; cs = 32'h8000_0000 | lowest(irq_pend & irq_en); ep = ev_pc;
      end else if (ev_valid) begin
        if (m_is_illegal()) begin
          tr = 1; il = 1; cs = 2; ep = ev_pc;
        end else if (ev_kind == 3'd1) begin
          tr = 1; cs = (m_priv == 3) ? 11 : 8; ep = ev_pc;
        end else if (ev_kind == 3'd2) begin
          m_priv = m_mpp; m_mie = m_mpie; m_mpie = 1; m_mpp = 0;
        end else if (ev_kind == 3'd3) begin
          m_stall = 1; m_rpc = ev_pc + 4;
        end else if (ev_kind == 3'd4 && csr_wr && m_priv == 3) begin
          if (csr_addr == 12'h300) begin
            m_mie = csr_wdata[3]; m_mpie = csr_wdata[7]; m_tw = csr_wdata[21];
            m_mpp = (csr_wdata[12:11] == 2'b11) ? 3 : 0;
          end else if (csr_addr == 12'h306) m_cnt = csr_wdata[7:0];
        end
      end
      if (tr) begin
        m_mpp = m_priv; m_mpie = m_mie; m_mie = 0; m_priv = 3;
        m_cause = cs; m_epc = ep;
      end
      m_trap = tr; m_ill = il;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R12", "trap_o",      32'(trap_o),      32'(m_trap));
      check("R5",  "illegal_o",   32'(illegal_o),   32'(m_ill));
      check("R2",  "mcause_o",    mcause_o,         m_cause);
      check("R2",  "mepc_o",      mepc_o,           m_epc);
      check("R4",  "priv_o",      32'(priv_o),      32'(m_priv));
      check("R7",  "wfi_stall_o", 32'(wfi_stall_o), 32'(m_stall));
      check("R11", "mstatus_o",   mstatus_o,
            (32'(m_mie) << 3) | (32'(m_mpie) << 7) | (32'(m_mpp) << 11) | (32'(m_tw) << 21));
      check("R6",  "mcounteren_o", 32'(mcounteren_o), 32'(m_cnt));
    end
  end

  task automatic ev(input logic [2:0] k, input logic [31:0] pc,
                    input logic [11:0] a = 12'h0, input logic w = 1'b0,
                    input logic [31:0] d = 32'h0);
    ev_valid = 1'b1; ev_kind = k; ev_pc = pc; csr_addr = a; csr_wr = w; csr_wdata = d;
    @(negedge clk);
    ev_valid = 1'b0; ev_kind = 3'd0; csr_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", "priv",  32'(priv_o), 32'd3);
    check("R1", "mstatus", mstatus_o, 32'h0);
    check("R1", "mcounteren", 32'(mcounteren_o), 32'h0);
    check("R1", "stall", 32'(wfi_stall_o), 32'h0);

    // R2/R3 ecall from M-mode
    ev(3'd1, 32'h100);
    check("R2", "cause ecall M", mcause_o, 32'd11);
    check("R2", "epc ecall M", mepc_o, 32'h100);
    check("R3", "saved mode M", 32'(mstatus_o[12:11]), 32'd3);

    // R4 mret into U
    ev(3'd4, 32'h104, 12'h300, 1'b1, 32'h0);
    ev(3'd2, 32'h108);
    check("R4", "priv after mret", 32'(priv_o), 32'd0);
    check("R4", "mstatus after mret", mstatus_o, 32'h80);

    // R2 ecall from U
    ev(3'd1, 32'h200);
    check("R2", "cause ecall U", mcause_o, 32'd8);
    check("R3", "saved mode U", 32'(mstatus_o[12:11]), 32'd0);
    idle(1);
    check("R12", "trap pulse ends", 32'(trap_o), 32'd0);

    // R4 mret in U is illegal
    ev(3'd2, 32'h204);
    ev(3'd2, 32'h208);
    check("R4", "illegal flag", 32'(illegal_o), 32'd1);
    check("R4", "cause", mcause_o, 32'd2);
    check("R4", "epc", mepc_o, 32'h208);

    // R5 machine-only instruction and M CSR from U
    ev(3'd2, 32'h20C);
    ev(3'd5, 32'h210);
    check("R5", "mpriv in U", mcause_o, 32'd2);
    ev(3'd2, 32'h214);
    ev(3'd4, 32'h218, 12'h300, 1'b0);
    check("R5", "mstatus read in U", 32'(illegal_o), 32'd1);

    // R6 counter permissions
    ev(3'd4, 32'h21C, 12'h306, 1'b1, 32'h5);
    check("R11", "mcounteren write", 32'(mcounteren_o), 32'h5);
    ev(3'd2, 32'h220);
    ev(3'd4, 32'h224, 12'hC00, 1'b0);
    check("R6", "permitted counter read", 32'(trap_o), 32'd0);
    ev(3'd4, 32'h228, 12'hC02, 1'b0);
    check("R6", "permitted counter 2", 32'(priv_o), 32'd0);
    ev(3'd4, 32'h22C, 12'hC01, 1'b0);
    check("R6", "denied counter 1", 32'(illegal_o), 32'd1);
    ev(3'd2, 32'h230);
    ev(3'd4, 32'h234, 12'hC09, 1'b0);
    check("R6", "counter beyond NCNT", 32'(illegal_o), 32'd1);
    ev(3'd2, 32'h238);
    ev(3'd4, 32'h23C, 12'hC00, 1'b1, 32'h1);
    check("R6", "counter write in U", 32'(illegal_o), 32'd1);
    ev(3'd4, 32'h240, 12'hC00, 1'b1, 32'h1);
    check("R6", "counter write in M", 32'(illegal_o), 32'd1);

    // R9 TW set: WFI in M stalls; R8 wake on disabled pending line
    ev(3'd4, 32'h244, 12'h300, 1'b1, 32'h0020_0000);
    ev(3'd3, 32'h248);
    check("R9", "WFI in M stalls", 32'(wfi_stall_o), 32'd1);
    ev(3'd1, 32'h24C);
    check("R12", "event ignored in stall", 32'(trap_o), 32'd0);
    irq_pend = 4'b0100;
    @(negedge clk);
    check("R8", "resume without trap", 32'(wfi_stall_o), 32'd0);
    check("R8", "no trap on resume", 32'(trap_o), 32'd0);
    irq_pend = 4'b0000;
    ev(3'd2, 32'h250);
    ev(3'd3, 32'h254);
    check("R9", "WFI in U with TW", 32'(illegal_o), 32'd1);

    // R7 WFI with MIE set
    irq_en = 4'b1010;
    ev(3'd4, 32'h300, 12'h300, 1'b1, 32'h8);
    ev(3'd3, 32'h304);
    irq_pend = 4'b0001;
    idle(2);
    check("R7", "disabled line keeps stall", 32'(wfi_stall_o), 32'd1);
    irq_pend = 4'b1011;
    @(negedge clk);
    check("R7", "wake trap", 32'(trap_o), 32'd1);
    check("R7", "wake cause", mcause_o, 32'h8000_0001);
    check("R7", "wake epc", mepc_o, 32'h308);
    irq_pend = 4'b0000;

    // R10 interrupt outside WFI discards the event
    ev(3'd4, 32'h400, 12'h300, 1'b1, 32'h8);
    irq_pend = 4'b1000;
    ev(3'd1, 32'h404);
    check("R10", "irq cause", mcause_o, 32'h8000_0003);
    check("R10", "irq epc", mepc_o, 32'h404);
    irq_pend = 4'b0000;

    // R11 field masking
    ev(3'd4, 32'h500, 12'h300, 1'b1, 32'hFFFF_FFFF);
    check("R11", "all ones", mstatus_o, 32'h0020_1888);
    ev(3'd4, 32'h504, 12'h300, 1'b1, 32'h0000_0800);
    check("R11", "mpp 01 reads U", mstatus_o, 32'h0);
    ev(3'd4, 32'h508, 12'h306, 1'b1, 32'hFFFF_FFFF);
    check("R11", "mcounteren width", 32'(mcounteren_o), 32'hFF);
    idle(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule